// File: doc/BRIEF.md
# Framed Response Packet Transmitter

This block assembles outgoing response frames for a host link and hands them, one byte at a time, to a byte-wide serial transmitter through a valid/ready handshake. A single-cycle start pulse captures a header made of a type byte, a length byte and a three-byte address. The block then sends a fixed opening marker, the header, a data payload that it fetches byte by byte from an external source, a CRC-8 check byte and a fixed closing marker.

The data source sees a one-cycle request for every payload byte. It answers with a valid strobe and the byte, after any number of cycles. The block asks for a byte only while it has nothing pending on its output, so a slow source and a slow transmitter can both stall the frame without losing or repeating a byte. The check byte is accumulated while each covered byte is accepted downstream, so the frame needs no buffer.

Top module: `frame_tx`

## Requirements
- R1: Every frame begins with the byte 0x3C and ends with the byte 0xA5.
- R2: Bytes are sent in this order: opening marker, type, length, address bits 23:16, address bits 15:8, address bits 7:0, payload bytes in the order the source supplied them, check byte, closing marker.
- R3: The length byte equals the latched len_i value, and the payload then holds len_i+1 bytes, from 1 (len_i=0) to 256 (len_i=255).
- R4: The check byte is a CRC-8 with polynomial x^8+x^2+x+1 (0x07). It starts from 0x00, is fed MSB first with no reflection and no final XOR, and covers the type, length, address and payload bytes, in the order they are sent.
- R5: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o does not change. Every byte of the frame is accepted exactly once, and no byte appears after the closing marker.
- R6: src_req_o is a single-cycle pulse. It occurs only during the payload phase, never while tx_valid_o is high, and exactly once per payload byte. The byte on src_data_i is taken in the cycle src_vld_i is high.
- R7: A start_i pulse while idle latches type_i, len_i and addr_i. busy_o rises in the next cycle with 0x3C already presented, and header inputs may change after that without effect. busy_o falls in the cycle after the closing marker is accepted.
- R8: A start_i pulse while busy_o is high is ignored: the frame in flight continues unchanged and no second frame follows.
- R9: During and right after reset, busy_o, tx_valid_o and src_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle request to send a frame |
| type_i | input | 8 | Frame type byte |
| len_i | input | 8 | Payload byte count minus one |
| addr_i | input | 24 | Address field |
| busy_o | output | 1 | High while a frame is in progress |
| src_req_o | output | 1 | Request pulse for the next payload byte |
| src_vld_i | input | 1 | Payload byte valid strobe from the source |
| src_data_i | input | 8 | Payload byte from the source |
| tx_data_o | output | 8 | Byte to the transmitter |
| tx_valid_o | output | 1 | tx_data_o holds a byte to send |
| tx_ready_i | input | 1 | Transmitter accepts the byte this cycle |

## Verification
The bench covers the single-byte payload and the full 256-byte payload. A length off by one would show up as a missing or extra payload byte and a wrong check byte. It applies backpressure patterns that stall on marker, header, payload and check bytes, so a design that advanced without ready would skip bytes, and one that reloaded its output register would send bytes twice. The source answers after differing delays, which exposes a design that requests ahead or counts requests wrongly. A start pulse in the middle of a frame checks that a busy block neither restarts nor queues a second frame.

// File: rtl/frame_tx_pkg.sv
`timescale 1ns/1ps
package frame_tx_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SOF,
      ST_TYPE,
      ST_LEN,
      ST_ADDR,
      ST_DREQ,
      ST_DWAIT,
      ST_DATA,
      ST_CRC,
      ST_EOF
   } ftx_state_e;

   localparam logic [7:0] FTX_OPEN  = 8'h3C;
   localparam logic [7:0] FTX_CLOSE = 8'hA5;

endpackage

// File: rtl/frame_tx_crc.sv
`timescale 1ns/1ps
module frame_tx_crc #(
   parameter int          W    = 8,
   parameter logic [W-1:0] POLY = 8'h07
) (
   input  logic [W-1:0] crc_i,
   input  logic [7:0]   byte_i,
   output logic [W-1:0] crc_o
);

   generate
      if (W < 2) begin : g_bad_width
         $error("frame_tx_crc: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] acc;
   logic         fb;

   always_comb begin
      acc = crc_i;
      fb  = 1'b0;
      for (int b = 7; b >= 0; b--) begin
         fb  = acc[W-1] ^ byte_i[b];
         acc = {acc[W-2:0], 1'b0};
         if (fb) begin
            acc = acc ^ POLY;
         end
      end
      crc_o = acc;
   end

endmodule

// File: rtl/frame_tx_addr_sel.sv
`timescale 1ns/1ps
module frame_tx_addr_sel #(
   parameter int ADDR_BYTES = 3,
   parameter bit MSB_FIRST  = 1'b1,
   parameter int IDX_W      = $clog2(ADDR_BYTES + 1)
) (
   input  logic [8*ADDR_BYTES-1:0] addr_i,
   input  logic [IDX_W-1:0]        idx_i,
   output logic [7:0]              byte_o
);

   logic [7:0]       lanes [ADDR_BYTES];
   logic [IDX_W-1:0] lane;

   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
      assign lanes[g] = addr_i[8*g +: 8];
   end

   generate
      if (MSB_FIRST) begin : g_msb_first
         assign lane = IDX_W'(ADDR_BYTES - 1) - idx_i;
      end else begin : g_lsb_first
         assign lane = idx_i;
      end
   endgenerate

   always_comb begin
      byte_o = 8'h00;
      for (int k = 0; k < ADDR_BYTES; k++) begin
         if (int'(lane) == k) begin
            byte_o = lanes[k];
         end
      end
   end

endmodule

// File: rtl/frame_tx.sv
`timescale 1ns/1ps
module frame_tx
   import frame_tx_pkg::*;
#(
   parameter int          ADDR_BYTES     = 3,
   parameter int          MAX_BYTES      = 256,
   parameter logic [7:0]  CRC_POLY       = 8'h07,
   parameter logic [7:0]  CRC_INIT       = 8'h00,
   parameter bit          ADDR_MSB_FIRST = 1'b1,
   parameter int          LEN_W          = $clog2(MAX_BYTES),
   parameter int          ADDR_W         = 8 * ADDR_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [7:0]        type_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              busy_o,
   output logic              src_req_o,
   input  logic              src_vld_i,
   input  logic [7:0]        src_data_i,
   output logic [7:0]        tx_data_o,
   output logic              tx_valid_o,
   input  logic              tx_ready_i
);

   localparam int AIDX_W = $clog2(ADDR_BYTES + 1);

   generate
      if (MAX_BYTES < 2 || MAX_BYTES > 256) begin : g_bad_max
         $error("frame_tx: MAX_BYTES must lie in 2..256, the length is one byte");
      end
      if (ADDR_BYTES < 1 || ADDR_BYTES > 8) begin : g_bad_addr
         $error("frame_tx: ADDR_BYTES must lie in 1..8");
      end
      if (LEN_W > 8) begin : g_bad_len
         $error("frame_tx: LEN_W must fit in one byte");
      end
   endgenerate

   ftx_state_e        state_q;
   logic [7:0]        type_q;
   logic [LEN_W-1:0]  len_q;
   logic [ADDR_W-1:0] addr_q;
   logic [AIDX_W-1:0] aidx_q;
   logic [LEN_W-1:0]  dcnt_q;
   logic [7:0]        crc_q;
   logic [7:0]        obyte_q;
   logic              ovalid_q;

   logic              hs;
   logic [7:0]        crc_nxt;
   logic [7:0]        addr_byte;

   assign hs = ovalid_q & tx_ready_i;

   frame_tx_crc #(
      .W    (8),
      .POLY (CRC_POLY)
   ) u_crc (
      .crc_i  (crc_q),
      .byte_i (obyte_q),
      .crc_o  (crc_nxt)
   );

   frame_tx_addr_sel #(
      .ADDR_BYTES (ADDR_BYTES),
      .MSB_FIRST  (ADDR_MSB_FIRST),
      .IDX_W      (AIDX_W)
   ) u_addr (
      .addr_i (addr_q),
      .idx_i  (aidx_q),
      .byte_o (addr_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         type_q   <= '0;
         len_q    <= '0;
         addr_q   <= '0;
         aidx_q   <= '0;
         dcnt_q   <= '0;
         crc_q    <= CRC_INIT;
         obyte_q  <= '0;
         ovalid_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  type_q   <= type_i;
                  len_q    <= len_i;
                  addr_q   <= addr_i;
                  aidx_q   <= '0;
                  dcnt_q   <= '0;
                  crc_q    <= CRC_INIT;
                  obyte_q  <= FTX_OPEN;
                  ovalid_q <= 1'b1;
                  state_q  <= ST_SOF;
               end
            end
            ST_SOF: begin
               if (hs) begin
                  obyte_q <= type_q;
                  state_q <= ST_TYPE;
               end
            end
            ST_TYPE: begin
               if (hs) begin
                  crc_q   <= crc_nxt;
                  obyte_q <= 8'(len_q);
                  state_q <= ST_LEN;
               end
            end
            ST_LEN: begin
               if (hs) begin
                  crc_q   <= crc_nxt;
                  obyte_q <= addr_byte;
                  aidx_q  <= aidx_q + 1'b1;
                  state_q <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               if (hs) begin
                  crc_q <= crc_nxt;
                  if (aidx_q == AIDX_W'(ADDR_BYTES)) begin
                     ovalid_q <= 1'b0;
                     state_q  <= ST_DREQ;
                  end else begin
                     obyte_q <= addr_byte;
                     aidx_q  <= aidx_q + 1'b1;
                  end
               end
            end
            ST_DREQ: begin
               state_q <= ST_DWAIT;
            end
            ST_DWAIT: begin
               if (src_vld_i) begin
                  obyte_q  <= src_data_i;
                  ovalid_q <= 1'b1;
                  state_q  <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (hs) begin
                  crc_q <= crc_nxt;
                  if (dcnt_q == len_q) begin
                     obyte_q <= crc_nxt;
                     state_q <= ST_CRC;
                  end else begin
                     dcnt_q   <= dcnt_q + 1'b1;
                     ovalid_q <= 1'b0;
                     state_q  <= ST_DREQ;
                  end
               end
            end
            ST_CRC: begin
               if (hs) begin
                  obyte_q <= FTX_CLOSE;
                  state_q <= ST_EOF;
               end
            end
            ST_EOF: begin
               if (hs) begin
                  ovalid_q <= 1'b0;
                  state_q  <= ST_IDLE;
               end
            end
            default: begin
               ovalid_q <= 1'b0;
               state_q  <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign src_req_o  = (state_q == ST_DREQ);
   assign tx_data_o  = obyte_q;
   assign tx_valid_o = ovalid_q;

endmodule

// File: rtl/frame_tx_chk.sv
`timescale 1ns/1ps
module frame_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy_o,
   input logic       src_req_o,
   input logic       src_vld_i,
   input logic [7:0] tx_data_o,
   input logic       tx_valid_o,
   input logic       tx_ready_i
);

   // R5: a stalled byte is held
   a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

   // R1, R7: the first byte shown when busy rises is the opening marker
   a_r1_open_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (tx_valid_o && tx_data_o == 8'h3C));

   // R7: busy ends only after the closing marker is accepted
   a_r7_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(tx_valid_o && tx_ready_i && tx_data_o == 8'hA5));

   // R6: requests only while busy with nothing pending
   a_r6_req_gap: assert property (@(posedge clk) disable iff (!rst_n)
      src_req_o |-> (busy_o && !tx_valid_o));

   // R6: a request is a single-cycle pulse
   a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      src_req_o |=> !src_req_o);

   // R9: idle outputs quiet
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!tx_valid_o && !src_req_o));

   // R6: no request in the cycle a byte arrives
   a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      src_vld_i |-> !src_req_o);

endmodule

bind frame_tx frame_tx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy_o     (busy_o),
   .src_req_o  (src_req_o),
   .src_vld_i  (src_vld_i),
   .tx_data_o  (tx_data_o),
   .tx_valid_o (tx_valid_o),
   .tx_ready_i (tx_ready_i)
);

// File: tb/tb_frame_tx.sv
`timescale 1ns/1ps
module tb_frame_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  typ = '0;
   logic [7:0]  len = '0;
   logic [23:0] addr = '0;
   logic        busy;
   logic        src_req;
   logic        src_vld = 1'b0;
   logic [7:0]  src_data = '0;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        tx_ready = 1'b0;

   frame_tx dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .type_i     (typ),
      .len_i      (len),
      .addr_i     (addr),
      .busy_o     (busy),
      .src_req_o  (src_req),
      .src_vld_i  (src_vld),
      .src_data_i (src_data),
      .tx_data_o  (tx_data),
      .tx_valid_o (tx_valid),
      .tx_ready_i (tx_ready)
   );

   always #5 clk = ~clk;

   logic [7:0] exp_q[$];
   int         kind_q[$];
   logic [7:0] src_q[$];
   int         checks = 0;
   int         failures = 0;
   int         rdy_mode = 0;
   int         src_lat = 0;
   int         req_cnt = 0;
   int         pend = 0;
   int         cyc = 0;
   bit         stall_prev = 1'b0;
   logic [7:0] held = '0;
   bit         done = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic string kname(input int k);
      case (k)
         0: return "R1 opening marker";
         1: return "R2 header byte";
         2: return "R3 length byte";
         3: return "R2 payload byte";
         4: return "R4 check byte";
         default: return "R1 closing marker";
      endcase
   endfunction

   function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
      logic [7:0] r;
      r = c ^ b;
      for (int i = 0; i < 8; i++) begin
         r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
      end
      return r;
   endfunction

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (stall_prev) begin
            check(tx_valid && tx_data == held, "R5 stalled byte held", int'(tx_data), int'(held));
         end
         if (tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected extra byte", int'(tx_data), 0);
            end else begin
               logic [7:0] e;
               int         k;
               e = exp_q.pop_front();
               k = kind_q.pop_front();
               check(tx_data == e, kname(k), int'(tx_data), int'(e));
            end
         end
         stall_prev = tx_valid && !tx_ready;
         held       = tx_data;
         if (src_req) begin
            req_cnt++;
            pend++;
            check(!tx_valid, "R6 request while byte pending", 1, 0);
         end
      end
   end

   // data source
   initial begin
      int wait_ctr;
      wait_ctr = 0;
      forever begin
         @(posedge clk);
         #2;
         src_vld = 1'b0;
         if (pend > 0) begin
            if (wait_ctr >= src_lat) begin
               src_vld  = 1'b1;
               src_data = (src_q.size() > 0) ? src_q.pop_front() : 8'h00;
               pend--;
               wait_ctr = 0;
            end else begin
               wait_ctr++;
            end
         end
      end
   end

   // downstream ready pattern
   initial begin
      forever begin
         @(posedge clk);
         #2;
         cyc++;
         case (rdy_mode)
            0: tx_ready = 1'b1;
            1: tx_ready = cyc[0];
            default: tx_ready = (cyc % 3 == 0);
         endcase
      end
   end

   task automatic send_frame(input logic [7:0] t, input logic [7:0] l, input logic [23:0] a,
                             input int lat, input int mode, input bit poke);
      logic [7:0] c;
      int         n;
      c = 8'h00;
      exp_q.push_back(8'h3C); kind_q.push_back(0);
      exp_q.push_back(t);     kind_q.push_back(1); c = crc_step(c, t);
      exp_q.push_back(l);     kind_q.push_back(2); c = crc_step(c, l);
      exp_q.push_back(a[23:16]); kind_q.push_back(1); c = crc_step(c, a[23:16]);
      exp_q.push_back(a[15:8]);  kind_q.push_back(1); c = crc_step(c, a[15:8]);
      exp_q.push_back(a[7:0]);   kind_q.push_back(1); c = crc_step(c, a[7:0]);
      for (int i = 0; i <= int'(l); i++) begin
         logic [7:0] d;
         d = 8'(i * 13 + int'(t) + 5);
         src_q.push_back(d);
         exp_q.push_back(d); kind_q.push_back(3);
         c = crc_step(c, d);
      end
      exp_q.push_back(c);     kind_q.push_back(4);
      exp_q.push_back(8'hA5); kind_q.push_back(5);
      rdy_mode = mode;
      src_lat  = lat;
      req_cnt  = 0;

      @(posedge clk); #2;
      start = 1'b1; typ = t; len = l; addr = a;
      @(negedge clk);
      check(!busy, "R7 busy low before start is taken", int'(busy), 0);
      @(posedge clk); #2;
      start = 1'b0; typ = ~t; len = ~l; addr = ~a;
      @(negedge clk);
      check(busy, "R7 busy high after start", int'(busy), 1);

      n = 0;
      while (busy && n < 5000) begin
         if (poke && n == 6) begin
            @(posedge clk); #2;
            start = 1'b1; typ = 8'hEE; len = 8'h07; addr = 24'h777777;
            @(posedge clk); #2;
            start = 1'b0;
            n += 2;
         end
         @(negedge clk);
         n++;
      end
      check(!busy, "R7 frame finished in time", int'(busy), 0);
      repeat (4) @(negedge clk);
      check(!busy, "R8 no second frame after busy start", int'(busy), 0);
      check(exp_q.size() == 0, "R5 all frame bytes sent once", exp_q.size(), 0);
      check(req_cnt == int'(l) + 1, "R6 one request per payload byte", req_cnt, int'(l) + 1);
      exp_q.delete();
      kind_q.delete();
      src_q.delete();
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(!busy && !tx_valid && !src_req, "R9 quiet during reset",
            int'({busy, tx_valid, src_req}), 0);
      @(posedge clk); #2;
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !tx_valid && !src_req, "R9 quiet after reset",
            int'({busy, tx_valid, src_req}), 0);

      send_frame(8'h11, 8'd0,   24'h123456, 0, 0, 1'b0); // R3 minimum payload
      send_frame(8'h22, 8'd3,   24'hABCDEF, 2, 1, 1'b0); // R5 alternating stall
      send_frame(8'h5A, 8'd255, 24'h000102, 1, 2, 1'b0); // R3 maximum payload
      send_frame(8'h33, 8'd4,   24'hFFFFFF, 0, 1, 1'b1); // R8 start while busy
      send_frame(8'h00, 8'd1,   24'h000000, 3, 0, 1'b0); // R4 zero header

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule